// File: doc/BRIEF.md
# Banked Index/Data Configuration Port

This block is the configuration front end of a legacy I/O peripheral. A host reaches it through two byte-wide bus addresses. The host writes a register number to the command address. It then reads or writes that register at the data address, which is the command address plus one. One input strap picks which of two command addresses the block answers. Fixed chip-level registers hold an identification byte, a chip configuration byte and a unit selector.

The unit selector chooses one of three logical device banks. Each bank has an activate byte and a 16-bit runtime base address split into high and low bytes. When the GPIO unit is selected, three more indices become live. The first is a packed pin-select byte, holding a port number in its upper nibble and a bit number in its low three bits. The other two give access to the configuration byte and the event byte of the pin that the pin-select byte names. Both bytes are held in per-pin storage inside the block.

Software changes a pin setting by reading the byte, masking it and writing it back. Reads have no side effects, so this sequence is safe.

Top module: `sio_cfg_port`

## Requirements
- R1: The command address is 0x2E when `altBase` is 0 and 0x4E when it is 1, and the data address is the command address plus one. Bus accesses to any other address change no state and produce no read response.
- R2: A read strobe on the command or data address gives a response one clock later: `busRdValid` is high for one cycle with the byte on `busRdData`. A read of the command address returns the current index, and `busRdValid` is 0 out of reset.
- R3: The index resets to 0x00. Index 0x20 always reads 0xE9, and writes to it are ignored.
- R4: Index 0x21 is the chip configuration byte. It resets to 0x01 (bit 0 is the chip-enable flag) and is read/write.
- R5: Index 0x07 is the unit selector. It resets to 0x07, accepts any byte and reads back what was written.
- R6: Indices 0x30 (activate), 0x60 (base high) and 0x61 (base low) act on the bank of the selected unit, which is 0x07, 0x0D or 0x0E, and the banks are independent. Out of reset, unit 0x07 has activate 0x01 and base 0x0680, and the other units hold zeros.
- R7: When the selector holds a value that is not one of the three units, indices 0x30, 0x60 and 0x61 read 0xFF and writes to them are ignored.
- R8: Index 0xF0 (pin select) exists only while unit 0x07 is selected. It resets to 0x00, keeps bits 7:4 (port) and 2:0 (bit), and reads bit 3 as 0. Under any other unit, indices 0xF0, 0xF1 and 0xF2 read 0xFF.
- R9: Indices 0xF1 and 0xF2 read and write the configuration byte and the event byte of pin `port*8+bit`, for ports 0 to 3. Each byte resets to 0x00 and is stored separately for each pin. Linear pin n is selected by writing ((n<<1)&0xF0)|(n&7) to 0xF0.
- R10: With a port number of 4 or more in the pin select, indices 0xF1 and 0xF2 read 0xFF, and writes to them leave every pin unchanged.
- R11: Indices outside {0x07, 0x20, 0x21, 0x30, 0x60, 0x61, 0xF0, 0xF1, 0xF2} read 0xFF, and writes to them are ignored.
- R12: Reads have no side effects. A read-modify-write new = (old & mask) | bits at 0xF1 returns the old value on the read and stores the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| altBase | input | 1 | Strap: 0 selects command address 0x2E, 1 selects 0x4E |
| busAddr | input | 8 | Bus address |
| busWrData | input | 8 | Bus write data |
| busWr | input | 1 | One-cycle write strobe |
| busRd | input | 1 | One-cycle read strobe |
| busRdData | output | 8 | Read response data |
| busRdValid | output | 1 | Read response valid, one cycle after the strobe |

## Verification
The assertions assume that `busRd` and `busWr` are never high in the same cycle. They also assume that `altBase` holds steady while a read is outstanding, because the checker keeps its own copy of the index and the unit selector and decodes addresses with the current strap. The bench drives each access as a single-cycle strobe followed by an idle cycle. It changes the strap only between accesses, so both conditions always hold.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int NUM_UNITS     = 3;
  localparam int GPIO_SLOT     = 0;
  localparam int PINS_PER_PORT = 8;

  // bank slot order; slot GPIO_SLOT is the pin-bearing unit
  localparam logic [NUM_UNITS-1:0][7:0] UNIT_IDS = {8'h0E, 8'h0D, 8'h07};

  localparam logic [7:0] IDX_UNIT_SEL = 8'h07;
  localparam logic [7:0] IDX_ID       = 8'h20;
  localparam logic [7:0] IDX_CHIP_CFG = 8'h21;
  localparam logic [7:0] IDX_ACT      = 8'h30;
  localparam logic [7:0] IDX_BASE_HI  = 8'h60;
  localparam logic [7:0] IDX_BASE_LO  = 8'h61;
  localparam logic [7:0] IDX_PIN_SEL  = 8'hF0;
  localparam logic [7:0] IDX_PIN_CFG  = 8'hF1;
  localparam logic [7:0] IDX_PIN_EVT  = 8'hF2;

  localparam logic [7:0] READ_FILL = 8'hFF;

  typedef struct packed {
    logic idxWr;
    logic idxRd;
    logic dataWr;
    logic dataRd;
  } cfgStrobe_t;
endpackage

// File: rtl/sio_cfg_ctrl.sv
module sio_cfg_ctrl
  import sio_cfg_pkg::*;
#(
  parameter logic [7:0] CMD_ADDR_A = 8'h2E,
  parameter logic [7:0] CMD_ADDR_B = 8'h4E
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       altBase,
  input  logic [7:0] busAddr,
  input  logic [7:0] busWrData,
  input  logic       busWr,
  input  logic       busRd,
  output cfgStrobe_t strobe,
  output logic [7:0] index,
  output logic       rdValid
);
  logic [7:0] cmdAddr;
  logic [7:0] dataAddr;
  logic       hitCmd;
  logic       hitData;

  assign cmdAddr  = altBase ? CMD_ADDR_B : CMD_ADDR_A;
  assign dataAddr = cmdAddr + 8'd1;
  assign hitCmd   = (busAddr == cmdAddr);
  assign hitData  = (busAddr == dataAddr);

  always_comb begin
    strobe.idxWr  = busWr & hitCmd;
    strobe.idxRd  = busRd & hitCmd;
    strobe.dataWr = busWr & hitData;
    strobe.dataRd = busRd & hitData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      index   <= 8'h00;
      rdValid <= 1'b0;
    end else begin
      if (strobe.idxWr) index <= busWrData;
      rdValid <= strobe.idxRd | strobe.dataRd;
    end
  end
endmodule

// File: rtl/sio_cfg_datapath.sv
module sio_cfg_datapath
  import sio_cfg_pkg::*;
#(
  parameter logic [7:0]  ID_VALUE        = 8'hE9,
  parameter logic [7:0]  CHIP_CFG_RESET  = 8'h01,
  parameter logic [15:0] GPIO_BASE_RESET = 16'h0680,
  parameter int          NUM_PORTS       = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  cfgStrobe_t strobe,
  input  logic [7:0] index,
  input  logic [7:0] wrData,
  output logic [7:0] rdData
);
  localparam int PORT_W   = $clog2(NUM_PORTS);
  localparam int PIN_W    = PORT_W + 3;
  localparam int NUM_PINS = NUM_PORTS * PINS_PER_PORT;
  localparam int SLOT_W   = $clog2(NUM_UNITS);

  logic [7:0] unitSel;
  logic [7:0] chipCfg;
  logic [7:0] unitAct    [NUM_UNITS];
  logic [7:0] unitBaseHi [NUM_UNITS];
  logic [7:0] unitBaseLo [NUM_UNITS];
  logic [7:0] pinCfgMem  [NUM_PINS];
  logic [7:0] pinEvtMem  [NUM_PINS];

  logic [3:0] pinPort;
  logic [2:0] pinBit;

  logic              slotHit;
  logic [SLOT_W-1:0] slotIdx;
  logic              gpioSel;
  logic              portOk;
  logic [PIN_W-1:0]  pinIdx;

  // unit lookup
  always_comb begin
    slotHit = 1'b0;
    slotIdx = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (unitSel == UNIT_IDS[u]) begin
        slotHit = 1'b1;
        slotIdx = SLOT_W'(u);
      end
    end
  end

  assign gpioSel = slotHit && (slotIdx == SLOT_W'(GPIO_SLOT));
  assign portOk  = int'(pinPort) < NUM_PORTS;
  assign pinIdx  = {pinPort[PORT_W-1:0], pinBit};

  // write decode
  logic wrUnit, wrChip, wrAct, wrHi, wrLo, wrPinSel, wrCfg, wrEvt;

  always_comb begin
    wrUnit   = 1'b0;
    wrChip   = 1'b0;
    wrAct    = 1'b0;
    wrHi     = 1'b0;
    wrLo     = 1'b0;
    wrPinSel = 1'b0;
    wrCfg    = 1'b0;
    wrEvt    = 1'b0;
    if (strobe.dataWr) begin
      case (index)
        IDX_UNIT_SEL: wrUnit   = 1'b1;
        IDX_CHIP_CFG: wrChip   = 1'b1;
        IDX_ACT:      wrAct    = slotHit;
        IDX_BASE_HI:  wrHi     = slotHit;
        IDX_BASE_LO:  wrLo     = slotHit;
        IDX_PIN_SEL:  wrPinSel = gpioSel;
        IDX_PIN_CFG:  wrCfg    = gpioSel & portOk;
        IDX_PIN_EVT:  wrEvt    = gpioSel & portOk;
        default: ;
      endcase
    end
  end

  // chip-level registers and pin selector
  always_ff @(posedge clk) begin
    if (!rstN) begin
      unitSel <= UNIT_IDS[GPIO_SLOT];
      chipCfg <= CHIP_CFG_RESET;
      pinPort <= 4'h0;
      pinBit  <= 3'h0;
    end else begin
      if (wrUnit) unitSel <= wrData;
      if (wrChip) chipCfg <= wrData;
      if (wrPinSel) begin
        pinPort <= wrData[7:4];
        pinBit  <= wrData[2:0];
      end
    end
  end

  // per-unit banks
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    localparam bit         IS_GPIO = (u == GPIO_SLOT);
    localparam logic [7:0] ACT_RST = IS_GPIO ? 8'h01 : 8'h00;
    localparam logic [7:0] HI_RST  = IS_GPIO ? GPIO_BASE_RESET[15:8] : 8'h00;
    localparam logic [7:0] LO_RST  = IS_GPIO ? GPIO_BASE_RESET[7:0] : 8'h00;
    logic thisSlot;
    assign thisSlot = (slotIdx == SLOT_W'(u));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        unitAct[u]    <= ACT_RST;
        unitBaseHi[u] <= HI_RST;
        unitBaseLo[u] <= LO_RST;
      end else begin
        if (wrAct && thisSlot) unitAct[u]    <= wrData;
        if (wrHi  && thisSlot) unitBaseHi[u] <= wrData;
        if (wrLo  && thisSlot) unitBaseLo[u] <= wrData;
      end
    end
  end

  // per-pin storage
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic thisPin;
    assign thisPin = (pinIdx == PIN_W'(p));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pinCfgMem[p] <= 8'h00;
        pinEvtMem[p] <= 8'h00;
      end else begin
        if (wrCfg && thisPin) pinCfgMem[p] <= wrData;
        if (wrEvt && thisPin) pinEvtMem[p] <= wrData;
      end
    end
  end

  // read mux
  logic [7:0] rdNext;

  always_comb begin
    rdNext = READ_FILL;
    if (strobe.idxRd) begin
      rdNext = index;
    end else begin
      case (index)
        IDX_ID:       rdNext = ID_VALUE;
        IDX_UNIT_SEL: rdNext = unitSel;
        IDX_CHIP_CFG: rdNext = chipCfg;
        IDX_ACT:      if (slotHit) rdNext = unitAct[slotIdx];
        IDX_BASE_HI:  if (slotHit) rdNext = unitBaseHi[slotIdx];
        IDX_BASE_LO:  if (slotHit) rdNext = unitBaseLo[slotIdx];
        IDX_PIN_SEL:  if (gpioSel) rdNext = {pinPort, 1'b0, pinBit};
        IDX_PIN_CFG:  if (gpioSel && portOk) rdNext = pinCfgMem[pinIdx];
        IDX_PIN_EVT:  if (gpioSel && portOk) rdNext = pinEvtMem[pinIdx];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= 8'h00;
    end else if (strobe.idxRd || strobe.dataRd) begin
      rdData <= rdNext;
    end
  end
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter logic [7:0]  CMD_ADDR_A      = 8'h2E,
  parameter logic [7:0]  CMD_ADDR_B      = 8'h4E,
  parameter logic [7:0]  ID_VALUE        = 8'hE9,
  parameter logic [7:0]  CHIP_CFG_RESET  = 8'h01,
  parameter logic [15:0] GPIO_BASE_RESET = 16'h0680,
  parameter int          NUM_PORTS       = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       altBase,
  input  logic [7:0] busAddr,
  input  logic [7:0] busWrData,
  input  logic       busWr,
  input  logic       busRd,
  output logic [7:0] busRdData,
  output logic       busRdValid
);
  cfgStrobe_t strobe;
  logic [7:0] index;

  sio_cfg_ctrl #(
    .CMD_ADDR_A(CMD_ADDR_A),
    .CMD_ADDR_B(CMD_ADDR_B)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .altBase  (altBase),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .busWr    (busWr),
    .busRd    (busRd),
    .strobe   (strobe),
    .index    (index),
    .rdValid  (busRdValid)
  );

  sio_cfg_datapath #(
    .ID_VALUE       (ID_VALUE),
    .CHIP_CFG_RESET (CHIP_CFG_RESET),
    .GPIO_BASE_RESET(GPIO_BASE_RESET),
    .NUM_PORTS      (NUM_PORTS)
  ) u_datapath (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .index (index),
    .wrData(busWrData),
    .rdData(busRdData)
  );
endmodule

// File: rtl/sio_cfg_checker.sv
module sio_cfg_checker #(
  parameter logic [7:0] CMD_ADDR_A = 8'h2E,
  parameter logic [7:0] CMD_ADDR_B = 8'h4E,
  parameter logic [7:0] ID_VALUE   = 8'hE9
) (
  input logic       clk,
  input logic       rstN,
  input logic       altBase,
  input logic [7:0] busAddr,
  input logic [7:0] busWrData,
  input logic       busWr,
  input logic       busRd,
  input logic [7:0] busRdData,
  input logic       busRdValid
);
  logic [7:0] cmdA;
  logic [7:0] dataA;
  logic       onCmd;
  logic       onData;
  logic       knownIdx;

  assign cmdA   = altBase ? CMD_ADDR_B : CMD_ADDR_A;
  assign dataA  = cmdA + 8'd1;
  assign onCmd  = (busAddr == cmdA);
  assign onData = (busAddr == dataA);

  // independent shadows of index and unit selector
  logic [7:0] shIdx;
  logic [7:0] shUnit;
  logic       lastAnyRd, lastCmdRd, lastIdRd, lastUnitRd, lastFillRd;
  logic [7:0] lastCmdVal, lastUnitVal;

  always_comb begin
    case (shIdx)
      8'h07, 8'h20, 8'h21, 8'h30, 8'h60, 8'h61, 8'hF0, 8'hF1, 8'hF2: knownIdx = 1'b1;
      default: knownIdx = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shIdx       <= 8'h00;
      shUnit      <= 8'h07;
      lastAnyRd   <= 1'b0;
      lastCmdRd   <= 1'b0;
      lastIdRd    <= 1'b0;
      lastUnitRd  <= 1'b0;
      lastFillRd  <= 1'b0;
      lastCmdVal  <= 8'h00;
      lastUnitVal <= 8'h00;
    end else begin
      if (busWr && onCmd) shIdx <= busWrData;
      if (busWr && onData && shIdx == 8'h07) shUnit <= busWrData;
      lastAnyRd   <= busRd && (onCmd || onData);
      lastCmdRd   <= busRd && onCmd;
      lastIdRd    <= busRd && onData && shIdx == 8'h20;
      lastUnitRd  <= busRd && onData && shIdx == 8'h07;
      lastFillRd  <= busRd && onData && !knownIdx;
      lastCmdVal  <= shIdx;
      lastUnitVal <= shUnit;
    end
  end

  assert_no_stray_response_R1: assert property (@(posedge clk) disable iff (!rstN)
    busRdValid |-> lastAnyRd);

  assert_response_follows_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    lastAnyRd |-> busRdValid);

  assert_index_readback_R2: assert property (@(posedge clk) disable iff (!rstN)
    lastCmdRd |-> busRdData == lastCmdVal);

  assert_id_value_R3: assert property (@(posedge clk) disable iff (!rstN)
    lastIdRd |-> busRdData == ID_VALUE);

  assert_unit_readback_R5: assert property (@(posedge clk) disable iff (!rstN)
    lastUnitRd |-> busRdData == lastUnitVal);

  assert_unknown_fill_R11: assert property (@(posedge clk) disable iff (!rstN)
    lastFillRd |-> busRdData == 8'hFF);

  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr));
endmodule

bind sio_cfg_port sio_cfg_checker #(
  .CMD_ADDR_A(CMD_ADDR_A),
  .CMD_ADDR_B(CMD_ADDR_B),
  .ID_VALUE  (ID_VALUE)
) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .altBase   (altBase),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .busWr     (busWr),
  .busRd     (busRd),
  .busRdData (busRdData),
  .busRdValid(busRdValid)
);

// File: tb/sio_cfg_port_bench.sv
`timescale 1ns/1ps
module sio_cfg_port_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       altBase = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic [7:0] busWrData = 8'h00;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busRdData;
  logic       busRdValid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] expQ[$];
  string      tagQ[$];
  logic [7:0] cfgModel [32];

  always #2 clk = ~clk;

  sio_cfg_port u_sio_cfg_port (
    .clk       (clk),
    .rstN      (rstN),
    .altBase   (altBase),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busWr     (busWr),
    .busRd     (busRd),
    .busRdData (busRdData),
    .busRdValid(busRdValid)
  );

  function automatic logic [7:0] cmdAddr();
    return altBase ? 8'h4E : 8'h2E;
  endfunction

  function automatic logic [7:0] pinCode(input int n);
    return 8'(((n << 1) & 8'hF0) | (n & 7));
  endfunction

  // monitor: pops expected bytes as responses appear
  always @(negedge clk) begin
    if (rstN && busRdValid) begin
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL R1 unexpected response: actual %02h expected none", busRdData);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (busRdData !== e) begin
          failures++;
          $display("FAIL %s read: actual %02h expected %02h", t, busRdData, e);
        end
      end
    end
  end

  task automatic busCycle(input logic [7:0] a, input logic [7:0] d, input logic wr, input logic rd);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = wr; busRd = rd;
    @(negedge clk);
    busWr = 1'b0; busRd = 1'b0;
  endtask

  task automatic setIdx(input logic [7:0] i);
    busCycle(cmdAddr(), i, 1'b1, 1'b0);
  endtask

  task automatic wrReg(input logic [7:0] i, input logic [7:0] v);
    setIdx(i);
    busCycle(cmdAddr() + 8'd1, v, 1'b1, 1'b0);
  endtask

  task automatic rdReg(input logic [7:0] i, input logic [7:0] e, input string t);
    setIdx(i);
    expQ.push_back(e); tagQ.push_back(t);
    busCycle(cmdAddr() + 8'd1, 8'h00, 1'b0, 1'b1);
  endtask

  task automatic rdCmd(input logic [7:0] e, input string t);
    expQ.push_back(e); tagQ.push_back(t);
    busCycle(cmdAddr(), 8'h00, 1'b0, 1'b1);
  endtask

  task automatic expectSilent(input logic [7:0] a, input string t);
    busCycle(a, 8'h00, 1'b0, 1'b1);
    checks++;
    if (busRdValid !== 1'b0) begin
      failures++;
      $display("FAIL %s stray read: actual valid %b expected 0", t, busRdValid);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (busRdValid !== 1'b0) begin
      failures++;
      $display("FAIL R2 reset valid: actual %b expected 0", busRdValid);
    end
    rstN = 1'b1;
    for (int n = 0; n < 32; n++) cfgModel[n] = 8'h00;

    // R3 index reset and identification byte
    rdCmd(8'h00, "R3");
    rdReg(8'h20, 8'hE9, "R3");
    wrReg(8'h20, 8'h12);
    rdReg(8'h20, 8'hE9, "R3");
    rdCmd(8'h20, "R2");

    // R4 chip configuration
    rdReg(8'h21, 8'h01, "R4");
    wrReg(8'h21, 8'h5A);
    rdReg(8'h21, 8'h5A, "R4");

    // R5 unit selector, R6 GPIO bank reset values
    rdReg(8'h07, 8'h07, "R5");
    rdReg(8'h30, 8'h01, "R6");
    rdReg(8'h60, 8'h06, "R6");
    rdReg(8'h61, 8'h80, "R6");

    // R6 bank independence
    wrReg(8'h07, 8'h0D);
    rdReg(8'h07, 8'h0D, "R5");
    rdReg(8'h30, 8'h00, "R6");
    wrReg(8'h30, 8'h01);
    wrReg(8'h60, 8'h03);
    rdReg(8'h60, 8'h03, "R6");
    rdReg(8'hF0, 8'hFF, "R8");
    rdReg(8'hF1, 8'hFF, "R8");
    wrReg(8'h07, 8'h0E);
    rdReg(8'h60, 8'h00, "R6");
    rdReg(8'h30, 8'h00, "R6");
    wrReg(8'h07, 8'h07);
    rdReg(8'h60, 8'h06, "R6");

    // R7 unknown unit
    wrReg(8'h07, 8'h22);
    rdReg(8'h30, 8'hFF, "R7");
    wrReg(8'h30, 8'h55);
    rdReg(8'h30, 8'hFF, "R7");
    rdReg(8'h61, 8'hFF, "R7");
    wrReg(8'h07, 8'h0D);
    rdReg(8'h30, 8'h01, "R7");

    // R8 pin select in GPIO unit
    wrReg(8'h07, 8'h07);
    rdReg(8'hF0, 8'h00, "R8");
    wrReg(8'hF0, 8'hFF);
    rdReg(8'hF0, 8'hF7, "R8");

    // R9 per-pin storage
    foreach (cfgModel[n]) begin
      if (n == 0 || n == 5 || n == 13 || n == 31) begin
        wrReg(8'hF0, pinCode(n));
        wrReg(8'hF1, 8'(n) ^ 8'hA5);
        wrReg(8'hF2, 8'(n + 1));
        cfgModel[n] = 8'(n) ^ 8'hA5;
      end
    end
    for (int n = 0; n < 32; n++) begin
      if (n == 0 || n == 5 || n == 7 || n == 13 || n == 31) begin
        wrReg(8'hF0, pinCode(n));
        rdReg(8'hF0, pinCode(n), "R9");
        rdReg(8'hF1, cfgModel[n], "R9");
        rdReg(8'hF2, (n == 7) ? 8'h00 : 8'(n + 1), "R9");
      end
    end

    // R12 read-modify-write on pin 13
    begin
      logic [7:0] oldV, newV;
      wrReg(8'hF0, pinCode(13));
      oldV = cfgModel[13];
      rdReg(8'hF1, oldV, "R12");
      newV = (oldV & 8'hF0) | 8'h03;
      wrReg(8'hF1, newV);
      cfgModel[13] = newV;
      rdReg(8'hF1, newV, "R12");
      rdReg(8'hF2, 8'd14, "R12");
    end

    // R10 port out of range
    wrReg(8'hF0, 8'h40);
    rdReg(8'hF1, 8'hFF, "R10");
    wrReg(8'hF1, 8'h11);
    wrReg(8'hF2, 8'h22);
    rdReg(8'hF2, 8'hFF, "R10");
    wrReg(8'hF0, 8'h00);
    rdReg(8'hF1, cfgModel[0], "R10");
    rdReg(8'hF2, 8'h01, "R10");

    // R11 unimplemented indices
    rdReg(8'h00, 8'hFF, "R11");
    wrReg(8'h55, 8'h33);
    rdReg(8'h55, 8'hFF, "R11");
    rdReg(8'h31, 8'hFF, "R11");

    // R1 address decode
    expectSilent(8'h4E, "R1");
    expectSilent(8'h2D, "R1");
    busCycle(8'h4E, 8'h21, 1'b1, 1'b0);
    busCycle(8'h4F, 8'h99, 1'b1, 1'b0);
    rdCmd(8'h31, "R1");
    altBase = 1'b1;
    rdCmd(8'h31, "R1");
    rdReg(8'h21, 8'h5A, "R1");
    expectSilent(8'h2E, "R1");
    expectSilent(8'h2F, "R1");
    altBase = 1'b0;
    rdCmd(8'h21, "R1");

    repeat (4) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL R2 missing responses: actual %0d pending expected 0", expQ.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule